// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block arbitrates the four interrupt sources of a classic UART and produces two results: a single active-high interrupt line, and an 8-bit identification value. The identification value carries a code for the most urgent source that is both pending and enabled. The source blocks supply level-type pending conditions. The bus interface supplies the enable bits and the strobes for register reads and for writes to the holding register.

Three sources are cleared by their own source blocks: line status, received data and modem status. This block only masks each of them during the read that acknowledges it, so that a stale interrupt does not stay visible for an extra cycle.

The transmit-empty condition is an edge-type event, so this block keeps its own pending flag for it. The flag sets when the holding register becomes empty, or when its enable bit is switched on while the register is already empty. The flag clears on a write to the holding register. It also clears on a read of the identification register that reports it, and that read produces a one-cycle acknowledge pulse.

Top module: `uart_irq_ident`

## Requirements
- R1: After the asynchronous reset, iir_o reads 0x01, irq_o is 0 and thre_ack_o is 0; the enables are assumed to be driven 0 by the register block.
- R2: With line status pending and ier_i[2] set, iir_o reads 0x06 one clock edge later.
- R3: With received data pending and ier_i[0] set, iir_o reads 0x04 one clock edge later.
- R4: With the transmit-empty flag set and ier_i[1] set, iir_o reads 0x02.
- R5: With modem status pending and ier_i[3] set, iir_o reads 0x00 one clock edge later.
- R6: When several enabled sources are pending, only the highest one is reported. The order from highest to lowest is line status, received data, transmit-empty, modem status.
- R7: A source whose enable bit is 0 is ignored. iir_o[7:4] always read 0.
- R8: irq_o is registered and equals the OR of all enabled pending sources. iir_o[0] is its inverse.
- R9: An identification read while iir_o reads 0x02 clears the transmit-empty flag and raises thre_ack_o for exactly one cycle. An identification read while iir_o shows any other code leaves the flag unchanged and gives no pulse.
- R10: A holding-register write clears the transmit-empty flag.
- R11: The transmit-empty flag sets on a 0-to-1 edge of thr_empty_i, or on a 0-to-1 change of ier_i[1] while thr_empty_i is 1.
- R12: While lsr_rd_i, rbr_rd_i or msr_rd_i is high, the matching source counts as not pending in the update made at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_i | input | 4 | Enables: [0] received data, [1] transmit-empty, [2] line status, [3] modem status |
| ls_pend_i | input | 1 | Line status condition pending |
| rx_pend_i | input | 1 | Received data available |
| thr_empty_i | input | 1 | Holding register empty level |
| ms_pend_i | input | 1 | Modem status change pending |
| iir_rd_i | input | 1 | Identification register read strobe |
| lsr_rd_i | input | 1 | Line status register read strobe |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| msr_rd_i | input | 1 | Modem status register read strobe |
| thr_wr_i | input | 1 | Holding register write strobe |
| irq_o | output | 1 | Interrupt line, active high |
| iir_o | output | 8 | Identification value |
| thre_ack_o | output | 1 | One-cycle pulse when a read acknowledges transmit-empty |

## Verification
Every result appears one clock edge after the stimulus that causes it. This covers a change of irq_o and iir_o after a change in pending, enable, read or write inputs, and it also covers the thre_ack_o pulse. The transmit-empty flag feeds the output registers through its next-state value, so an empty edge or an acknowledging read also shows up in iir_o after one edge, not two. The bench drives inputs at the falling edge and samples at the next falling edge. Every check therefore falls exactly one rising edge after its stimulus, and a check made one more cycle later confirms that the acknowledge pulse has ended.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_SRC   = 4;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned IIR_W     = 8;
  // priority index: 3 = highest
  localparam int unsigned SRC_LS    = 3;
  localparam int unsigned SRC_RX    = 2;
  localparam int unsigned SRC_THRE  = 1;
  localparam int unsigned SRC_MS    = 0;
  localparam logic [CODE_W-1:0] CODE_NONE = 4'b0001;

  function automatic logic [CODE_W-1:0] src_code(input int unsigned idx);
    case (idx)
      SRC_LS:   return 4'b0110;
      SRC_RX:   return 4'b0100;
      SRC_THRE: return 4'b0010;
      default:  return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/irq_thre_tracker.sv
module irq_thre_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic empty_i,
  input  logic wr_i,
  input  logic ack_rd_i,
  output logic pend_next_o,
  output logic ack_o
);
  logic pend_q, empty_q, en_q, arm, clr;

  assign arm = (empty_i & ~empty_q) | (en_i & ~en_q & empty_i);
  assign clr = wr_i | ack_rd_i;
  // clear wins: a write refills the register, an ack consumes the event
  assign pend_next_o = clr ? 1'b0 : (arm ? 1'b1 : pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      empty_q <= 1'b1;
      en_q    <= 1'b0;
      ack_o   <= 1'b0;
    end else begin
      pend_q  <= pend_next_o;
      empty_q <= empty_i;
      en_q    <= en_i;
      ack_o   <= ack_rd_i & pend_q;
    end
  end

  assert_wr_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !pend_q);
  assert_ack_after_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(ack_rd_i));
  assert_ack_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o || $past(ack_rd_i));
endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  output logic [NUM_SRC-1:0] gnt_o,
  output logic [CODE_W-1:0]  code_o,
  output logic               any_o
);
  always_comb begin
    gnt_o  = '0;
    code_o = CODE_NONE;
    for (int unsigned i = 0; i < NUM_SRC; i++) begin
      if (req_i[i]) begin
        gnt_o  = '0;
        gnt_o[i] = 1'b1;
        code_o = src_code(i);
      end
    end
  end

  assign any_o = |req_i;

  always_comb begin
    assert_gnt_onehot_R6: assert ($onehot0(gnt_o));
    assert_gnt_when_req_R8: assert ((gnt_o != '0) == any_o);
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] ier_i,
  input  logic               ls_pend_i,
  input  logic               rx_pend_i,
  input  logic               thr_empty_i,
  input  logic               ms_pend_i,
  input  logic               iir_rd_i,
  input  logic               lsr_rd_i,
  input  logic               rbr_rd_i,
  input  logic               msr_rd_i,
  input  logic               thr_wr_i,
  output logic               irq_o,
  output logic [IIR_W-1:0]   iir_o,
  output logic               thre_ack_o
);
  localparam int unsigned PAD_W = IIR_W - CODE_W;

  logic               thre_next, thre_hit, any;
  logic [NUM_SRC-1:0] req, gnt;
  logic [CODE_W-1:0]  code, code_q;

  // read only acknowledges transmit-empty when that is what was reported
  assign thre_hit = iir_rd_i && (code_q == src_code(SRC_THRE));

  irq_thre_tracker u_thre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ier_i[1]),
    .empty_i    (thr_empty_i),
    .wr_i       (thr_wr_i),
    .ack_rd_i   (thre_hit),
    .pend_next_o(thre_next),
    .ack_o      (thre_ack_o)
  );

  always_comb begin
    req           = '0;
    req[SRC_LS]   = ls_pend_i & ier_i[2] & ~lsr_rd_i;
    req[SRC_RX]   = rx_pend_i & ier_i[0] & ~rbr_rd_i;
    req[SRC_THRE] = thre_next & ier_i[1];
    req[SRC_MS]   = ms_pend_i & ier_i[3] & ~msr_rd_i;
  end

  irq_prio_encoder u_enc (
    .req_i (req),
    .gnt_o (gnt),
    .code_o(code),
    .any_o (any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= CODE_NONE;
      irq_o  <= 1'b0;
    end else begin
      code_q <= code;
      irq_o  <= any;
    end
  end

  assign iir_o = {{PAD_W{1'b0}}, code_q};

  assert_irq_vs_iir_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !iir_o[0]);
  assert_upper_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[IIR_W-1:CODE_W] == '0);
  assert_masked_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_i == '0) |=> !irq_o);
  assert_ls_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ls_pend_i && ier_i[2] && !lsr_rd_i) |=> (iir_o == 8'h06));
  assert_lsr_rd_mask_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_rd_i |=> (iir_o != 8'h06));
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {ier[3:0], ls, rx, ms, expected iir[7:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    {4'hF, 3'b000, 8'h01},
    {4'h4, 3'b100, 8'h06},
    {4'h1, 3'b010, 8'h04},
    {4'h8, 3'b001, 8'h00},
    {4'hF, 3'b111, 8'h06},
    {4'hF, 3'b011, 8'h04},
    {4'h0, 3'b111, 8'h01},
    {4'hB, 3'b101, 8'h00},
    {4'h4, 3'b011, 8'h01}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] ier = '0;
  logic ls = 0, rx = 0, thr_empty = 1, ms = 0;
  logic iir_rd = 0, lsr_rd = 0, rbr_rd = 0, msr_rd = 0, thr_wr = 0;
  logic irq, thre_ack;
  logic [7:0] iir;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk_i(clk), .rst_ni(rst_n), .ier_i(ier),
    .ls_pend_i(ls), .rx_pend_i(rx), .thr_empty_i(thr_empty), .ms_pend_i(ms),
    .iir_rd_i(iir_rd), .lsr_rd_i(lsr_rd), .rbr_rd_i(rbr_rd), .msr_rd_i(msr_rd),
    .thr_wr_i(thr_wr), .irq_o(irq), .iir_o(iir), .thre_ack_o(thre_ack)
  );

  function automatic string vec_tag(input int i);
    case (i)
      1: return "R2";
      2: return "R3";
      3: return "R5";
      4, 5: return "R6";
      6, 7, 8: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    // R1 reset state
    chk("R1 iir", iir, 8'h01);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 ack", {7'b0, thre_ack}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 iir after release", iir, 8'h01);

    // table walk, transmit-empty held disabled
    for (int i = 0; i < NVEC; i++) begin
      {ier, ls, rx, ms} = VEC[i][14:8];
      ier[1] = 1'b0;
      tick();
      chk(vec_tag(i), iir, VEC[i][7:0]);
      chk("R8 irq", {7'b0, irq}, {7'b0, ~VEC[i][0]});
    end
    ls = 0; rx = 0; ms = 0; ier = '0;
    tick();

    // R11 enable rise while already empty
    ier = 4'b0010;
    tick();
    chk("R11 enable arm", iir, 8'h02);
    chk("R4 irq", {7'b0, irq}, 8'h01);
    // R9 acknowledging read
    iir_rd = 1; tick(); iir_rd = 0;
    chk("R9 cleared", iir, 8'h01);
    chk("R9 ack pulse", {7'b0, thre_ack}, 8'h01);
    tick();
    chk("R9 ack ends", {7'b0, thre_ack}, 8'h00);
    // R11 empty edge
    thr_empty = 0; tick();
    chk("R11 no arm while full", iir, 8'h01);
    thr_empty = 1; tick();
    chk("R11 empty edge", iir, 8'h02);
    // R10 write clears
    thr_wr = 1; thr_empty = 0; tick(); thr_wr = 0;
    chk("R10 write clears", iir, 8'h01);
    thr_empty = 1; tick();
    chk("R4 rearmed", iir, 8'h02);
    // R6 transmit-empty above modem, then ack exposes modem
    ier = 4'b1010; ms = 1; tick();
    chk("R6 thre over modem", iir, 8'h02);
    iir_rd = 1; tick(); iir_rd = 0;
    chk("R9 modem exposed", iir, 8'h00);
    chk("R9 ack pulse 2", {7'b0, thre_ack}, 8'h01);
    // R9 read reporting modem does not ack
    iir_rd = 1; tick(); iir_rd = 0;
    chk("R9 no ack on modem", {7'b0, thre_ack}, 8'h00);
    chk("R9 modem stays", iir, 8'h00);
    // R12 msr read masks modem source
    msr_rd = 1; tick(); msr_rd = 0;
    chk("R12 msr mask", iir, 8'h01);
    ms = 0; tick();
    chk("R12 after clear", iir, 8'h01);
    // R12 lsr and rbr reads
    ier = 4'b0101; ls = 1; rx = 1; lsr_rd = 1; tick(); lsr_rd = 0;
    chk("R12 lsr mask shows rx", iir, 8'h04);
    rbr_rd = 1; tick(); rbr_rd = 0;
    chk("R12 rbr mask shows ls", iir, 8'h06);
    ls = 0; rx = 0; tick();
    chk("R8 idle", {7'b0, irq}, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule